// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the address sequence for a four-beat burst in a synchronous burst memory. A burst starts when either of two load strobes is high at a rising clock edge. One strobe serves the processor side and the other serves the cache-controller side. On that edge the block captures the full external address and the order-select input. On later edges the advance input moves an internal 2-bit beat counter forward by one. The low two address bits then follow the selected order, and the upper bits stay fixed at their captured value.

There are two orders. Linear order adds the beat count to the starting low bits and wraps modulo four. Interleaved order XORs the starting low bits with the beat count. The block drives the full burst address and the beat index. Both outputs come straight from registers through a small combinational map, so they change only after a rising edge.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_ni is low, and after it is released until the first load, burst_addr_o and beat_o are both zero.
- R2: At a rising edge where cpu_strobe_i or ctl_strobe_i is 1, the block captures addr_i. After that edge, burst_addr_o equals the captured address and beat_o is 0.
- R3: With no strobe, a rising edge with adv_i=1 increments beat_o by one, modulo 4. A rising edge with adv_i=0 leaves beat_o and burst_addr_o unchanged.
- R4: With order_i=0 captured at load (linear order), the low two bits of burst_addr_o equal (start + beat_o) mod 4. For example, a start of 2 gives 2,3,0,1.
- R5: With order_i=1 captured at load (interleaved order, also used when the pin floats high), the low two bits equal start XOR beat_o. For example, a start of 1 gives 1,0,3,2.
- R6: A strobe at the same edge as adv_i=1 takes priority. The new address is loaded and beat_o restarts at 0.
- R7: After four advances the beat wraps to 0 and burst_addr_o returns to the start address.
- R8: The address bits above bit 1 of burst_addr_o do not change between loads.
- R9: order_i is captured only at a load. Changes to order_i during a burst have no effect on the sequence.
- R10: Both strobes high at the same edge behave exactly like a single strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_strobe_i | input | 1 | Processor-side load strobe |
| ctl_strobe_i | input | 1 | Controller-side load strobe |
| adv_i | input | 1 | Advance to the next beat |
| order_i | input | 1 | 0 = linear order, 1 = interleaved order |
| addr_i | input | ADDR_W | External start address |
| burst_addr_o | output | ADDR_W | Current burst address |
| beat_o | output | 2 | Current beat index |

## Verification
A load strobe and the advance input can both be high at the same clock edge. The load and the counter step then compete for the same registers. The bench sets up this conflict in the middle of a burst, with the beat count non-zero and a new address of a different start. After the edge it checks that the new address appears with beat 0 and that no step has been added. The bench also changes the order input in the middle of a burst, at the same edges as advances, to confirm that only a load samples it.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int unsigned BEAT_W = 2;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_start_reg.sv
module burst_start_reg
  import burst_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              order_i,
  output logic [ADDR_W-1:0] base_o,
  output burst_order_e      order_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o  <= '0;
      order_o <= ORD_LINEAR;
    end else if (load_i) begin
      base_o  <= addr_i;
      order_o <= order_i ? ORD_INTERLEAVE : ORD_LINEAR;
    end
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_i,
  output logic [BEAT_W-1:0] beat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     beat_o <= '0;
    else if (load_i) beat_o <= '0;              // load wins over advance
    else if (adv_i)  beat_o <= beat_o + 1'b1;   // natural wrap modulo 2**BEAT_W
  end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
(
  input  logic [BEAT_W-1:0] start_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  burst_order_e      order_i,
  output logic [BEAT_W-1:0] low_o
);
  logic [BEAT_W-1:0] lin_low;
  logic [BEAT_W-1:0] ilv_low;

  assign lin_low = start_i + beat_i;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
    assign ilv_low[b] = start_i[b] ^ beat_i[b];
  end

  assign low_o = (order_i == ORD_INTERLEAVE) ? ilv_low : lin_low;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_strobe_i,
  input  logic              ctl_strobe_i,
  input  logic              adv_i,
  input  logic              order_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] burst_addr_o,
  output logic [BEAT_W-1:0] beat_o
);
  localparam int unsigned UPPER_W = ADDR_W - BEAT_W;

  logic              load;
  logic [ADDR_W-1:0] base_q;
  burst_order_e      order_q;
  logic [BEAT_W-1:0] low;

  assign load = cpu_strobe_i | ctl_strobe_i;

  burst_start_reg #(.ADDR_W(ADDR_W)) u_start (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .addr_i (addr_i),
    .order_i(order_i),
    .base_o (base_q),
    .order_o(order_q)
  );

  burst_beat_ctr u_beat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .adv_i (adv_i),
    .beat_o(beat_o)
  );

  burst_order_map u_map (
    .start_i(base_q[BEAT_W-1:0]),
    .beat_i (beat_o),
    .order_i(order_q),
    .low_o  (low)
  );

  assign burst_addr_o = {base_q[ADDR_W-1 -: UPPER_W], low};
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk
  import burst_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_strobe_i,
  input logic              ctl_strobe_i,
  input logic              adv_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] burst_addr_o,
  input logic [BEAT_W-1:0] beat_o
);
  logic any_strobe;
  assign any_strobe = cpu_strobe_i | ctl_strobe_i;

  a_r2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_strobe |=> (beat_o == '0) && (burst_addr_o == $past(addr_i)));

  a_r3_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!any_strobe && adv_i) |=> beat_o == BEAT_W'($past(beat_o) + 1'b1));

  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!any_strobe && !adv_i) |=> $stable(beat_o) && $stable(burst_addr_o));

  a_r6_priority: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_strobe && adv_i) |=> beat_o == '0);

  a_r8_upper_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_strobe |=> $stable(burst_addr_o[ADDR_W-1:BEAT_W]));

  a_r7_wrap_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!any_strobe && adv_i && beat_o == 2'd3) |=> beat_o == '0);
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpu_strobe_i(cpu_strobe_i),
  .ctl_strobe_i(ctl_strobe_i),
  .adv_i       (adv_i),
  .addr_i      (addr_i),
  .burst_addr_o(burst_addr_o),
  .beat_o      (beat_o)
);

// File: tb/tb_burst_addr_gen.sv
`timescale 1ns/1ps
module tb_burst_addr_gen;
  localparam int unsigned ADDR_W = 20;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cpu_strobe_i = 1'b0;
  logic              ctl_strobe_i = 1'b0;
  logic              adv_i = 1'b0;
  logic              order_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [ADDR_W-1:0] burst_addr_o;
  logic [1:0]        beat_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #10 clk_i = ~clk_i;

  burst_addr_gen #(.ADDR_W(ADDR_W)) dut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected low bits from the requirement definitions
  function automatic logic [1:0] exp_low(input logic ilv, input logic [1:0] s, input logic [1:0] b);
    return ilv ? (s ^ b) : 2'(s + b);
  endfunction

  // drive one cycle: inputs set after negedge, result sampled at next negedge
  task automatic cyc(input logic cs, input logic ks, input logic adv, input logic ord,
                     input logic [ADDR_W-1:0] a);
    cpu_strobe_i = cs; ctl_strobe_i = ks; adv_i = adv; order_i = ord; addr_i = a;
    @(posedge clk_i);
    @(negedge clk_i);
    cpu_strobe_i = 1'b0; ctl_strobe_i = 1'b0; adv_i = 1'b0;
  endtask

  task automatic run_burst(input string tag, input logic ilv, input logic [ADDR_W-1:0] a,
                           input logic use_ctl);
    cyc(!use_ctl, use_ctl, 1'b0, ilv, a);
    check({tag, " R2 load addr"}, 32'(burst_addr_o), 32'(a));
    check({tag, " R2 beat0"}, 32'(beat_o), 0);
    for (int k = 1; k <= 4; k++) begin
      cyc(1'b0, 1'b0, 1'b1, ~ilv, '0);  // order_i toggled: must be ignored (R9)
      check({tag, ilv ? " R5 seq" : " R4 seq"}, 32'(burst_addr_o[1:0]),
            32'(exp_low(ilv, a[1:0], 2'(k))));
      check({tag, " R8 upper"}, 32'(burst_addr_o[ADDR_W-1:2]), 32'(a[ADDR_W-1:2]));
      check({tag, " R3 beat"}, 32'(beat_o), 32'(k % 4));
    end
    check({tag, " R7 wrap"}, 32'(burst_addr_o), 32'(a));
  endtask

  task automatic t_reset();
    check("R1 addr in reset", 32'(burst_addr_o), 0);
    check("R1 beat in reset", 32'(beat_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 20'hFFFFF);
    check("R1 addr after reset", 32'(burst_addr_o), 0);
  endtask

  task automatic t_linear();
    run_burst("lin start2 R9", 1'b0, 20'h5A5A6, 1'b0);
    run_burst("lin start3", 1'b0, 20'h12343, 1'b1);
  endtask

  task automatic t_interleave();
    run_burst("ilv start1 R9", 1'b1, 20'hABCD1, 1'b0);
    run_burst("ilv start2", 1'b1, 20'h0F0F2, 1'b1);
  endtask

  task automatic t_hold();
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 20'h33330);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, '0);
    for (int k = 0; k < 3; k++) begin
      cyc(1'b0, 1'b0, 1'b0, 1'b1, 20'hFFFFF);
      check("R3 hold beat", 32'(beat_o), 1);
      check("R3 hold addr", 32'(burst_addr_o), 32'h33331);
    end
  endtask

  task automatic t_priority();
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 20'h44441);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, '0);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, '0);
    check("R6 pre beat", 32'(beat_o), 2);
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 20'h77772);
    check("R6 strobe+adv beat", 32'(beat_o), 0);
    check("R6 strobe+adv addr", 32'(burst_addr_o), 32'h77772);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, '0);
    check("R6 new order interleaved R5", 32'(burst_addr_o[1:0]), 3);
  endtask

  task automatic t_dual();
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 20'h88883);
    check("R10 dual addr", 32'(burst_addr_o), 32'h88883);
    check("R10 dual beat", 32'(beat_o), 0);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, '0);
    check("R10 dual next R4", 32'(burst_addr_o), 32'h88880);
  endtask

  initial begin
    @(negedge clk_i);
    t_reset();
    t_linear();
    t_interleave();
    t_hold();
    t_priority();
    t_dual();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        n_checks++; n_fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule